// File: doc/BRIEF.md
# Burst serial-to-I/Q demultiplexer

This block sits at the front of a burst QPSK transmitter. It runs on one master clock and divides it by a fixed ratio to produce the data clock, which an external source uses to present one serial bit per data-clock period. On every rising edge of that data clock it samples the serial bit and the transmit-enable input. It then steers the bits alternately into in-phase and quadrature positions and presents each completed pair with a one-cycle strobe to the pulse-shaping stage that follows.

A burst starts when transmit-enable is seen high. The pairing phase is then cleared, so the first bit of every burst is an I bit. When transmit-enable is seen low, the block keeps its output-enable flag raised for a fixed number of symbol periods and feeds zero symbols in that time, so the shaping filter can empty itself before the transmitter turns off. An active-low reset clears the outputs at once. Normal operation resumes two master-clock periods after the reset is released.

Top module: `burst_iq_demux`

## Requirements
- R1: `data_clk` has a period of DIV master-clock cycles (default 100). It is high for the first DIV/2 cycles of each period and low for the rest, and it reads high while in reset.
- R2: `tx_en` and `tx_data` are sampled only on the master-clock edge where `data_clk` rises, called a tick. Values at other times have no effect.
- R3: Within a burst, the first sampled bit is held as I and the next bit is taken as Q. On the tick of the Q bit, `sym_valid` pulses for one cycle with `sym_i`/`sym_q` set to the pair and `sym_zero`=0. The pattern then repeats, giving one strobe per two ticks.
- R4: A tick with `tx_en` high while idle or while draining starts a new burst. The bit sampled on that tick is I, whatever the previous pairing phase was.
- R5: A tick with `tx_en` low during a burst starts draining. An I bit still waiting for its Q partner is dropped and gives no strobe.
- R6: While draining, a zero symbol (`sym_valid`=1, `sym_zero`=1, `sym_i`=`sym_q`=0) is issued on every second tick, FLUSH_SYMS of them (default 8). `burst_on` falls on the same edge as the last zero symbol.
- R7: When `rst_n` goes low, `burst_on` and `sym_valid` go to 0 at once, without waiting for a clock edge.
- R8: After `rst_n` rises, the block stays in reset for two master-clock edges and operates from the third. The divider restarts at the beginning of a high phase.
- R9: `burst_on` rises on the tick that starts a burst and stays high through the burst and the drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asserts asynchronously |
| tx_en | input | 1 | Transmit enable from the burst source |
| tx_data | input | 1 | Serial data bit, presented against `data_clk` |
| data_clk | output | 1 | Derived data clock for the serial source |
| burst_on | output | 1 | Output-enable flag for the downstream stages |
| sym_valid | output | 1 | One-cycle strobe for a symbol pair |
| sym_i | output | 1 | In-phase bit of the pair |
| sym_q | output | 1 | Quadrature bit of the pair |
| sym_zero | output | 1 | Marks a zero (flush) symbol |

## Verification
If the pairing phase is wrong, I and Q come out swapped on the first strobe of a burst, or a strobe appears one tick early. This shows up within two data-clock periods of the burst start. A drain counter that is off by one moves the fall of `burst_on` and the count of zero symbols, and this is seen at the end of the drain, no more than 2*FLUSH_SYMS ticks after the enable drops. A slip in the divider shifts the `data_clk` edge within the first period after reset, so every output is compared against an independent model on each master-clock cycle.

// File: rtl/burst_iq_pkg.sv
package burst_iq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_DRAIN = 2'd2
  } burst_state_t;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_int = ~chain[STAGES-1];
endmodule

// File: rtl/burst_dclk_gen.sv
module burst_dclk_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_int,
  output logic data_clk,
  output logic tick
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] HALFV = CW'(HALF);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  assign tick    = (cnt == LAST);
  assign cnt_nxt = tick ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      cnt      <= '0;
      data_clk <= 1'b1;
    end else begin
      cnt      <= cnt_nxt;
      data_clk <= (cnt_nxt < HALFV);
    end
  end
endmodule

// File: rtl/burst_iq_steer.sv
module burst_iq_steer
  import burst_iq_pkg::*;
#(
  parameter int FLUSH_SYMS = 8
) (
  input  logic clk,
  input  logic rst_int,
  input  logic tick,
  input  logic tx_en,
  input  logic tx_data,
  output logic burst_on,
  output logic sym_valid,
  output logic sym_i,
  output logic sym_q,
  output logic sym_zero
);
  localparam int FTICKS = 2 * FLUSH_SYMS;
  localparam int FW     = $clog2(FTICKS);
  localparam logic [FW-1:0] FLAST = FW'(FTICKS - 1);

  burst_state_t  state;
  logic          half_full;
  logic          held_i;
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      state     <= ST_IDLE;
      half_full <= 1'b0;
      held_i    <= 1'b0;
      fcnt      <= '0;
      burst_on  <= 1'b0;
      sym_valid <= 1'b0;
      sym_i     <= 1'b0;
      sym_q     <= 1'b0;
      sym_zero  <= 1'b0;
    end else begin
      sym_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_BURST: begin
            if (tx_en) begin
              if (half_full) begin
                sym_valid <= 1'b1;
                sym_i     <= held_i;
                sym_q     <= tx_data;
                sym_zero  <= 1'b0;
                half_full <= 1'b0;
              end else begin
                held_i    <= tx_data;
                half_full <= 1'b1;
              end
            end else begin
              state     <= ST_DRAIN;
              half_full <= 1'b0;
              fcnt      <= '0;
            end
          end
          default: begin
            if (tx_en) begin
              state     <= ST_BURST;
              held_i    <= tx_data;
              half_full <= 1'b1;
              burst_on  <= 1'b1;
            end else if (state == ST_DRAIN) begin
              if (fcnt[0]) begin
                sym_valid <= 1'b1;
                sym_i     <= 1'b0;
                sym_q     <= 1'b0;
                sym_zero  <= 1'b1;
              end
              if (fcnt == FLAST) begin
                state    <= ST_IDLE;
                burst_on <= 1'b0;
              end
              fcnt <= fcnt + 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/burst_iq_demux.sv
module burst_iq_demux #(
  parameter int DIV        = 100,
  parameter int FLUSH_SYMS = 8,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  output logic data_clk,
  output logic burst_on,
  output logic sym_valid,
  output logic sym_i,
  output logic sym_q,
  output logic sym_zero
);
  logic rst_int;
  logic tick;

  burst_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_int (rst_int)
  );

  burst_dclk_gen #(.DIV(DIV)) u_dclk (
    .clk      (clk),
    .rst_int  (rst_int),
    .data_clk (data_clk),
    .tick     (tick)
  );

  burst_iq_steer #(.FLUSH_SYMS(FLUSH_SYMS)) u_steer (
    .clk       (clk),
    .rst_int   (rst_int),
    .tick      (tick),
    .tx_en     (tx_en),
    .tx_data   (tx_data),
    .burst_on  (burst_on),
    .sym_valid (sym_valid),
    .sym_i     (sym_i),
    .sym_q     (sym_q),
    .sym_zero  (sym_zero)
  );
endmodule

// File: rtl/burst_iq_demux_chk.sv
module burst_iq_demux_chk (
  input logic clk,
  input logic rst_int,
  input logic data_clk,
  input logic burst_on,
  input logic sym_valid,
  input logic sym_i,
  input logic sym_q,
  input logic sym_zero
);
  // R3
  data_strobe_in_burst_chk: assert property (@(posedge clk) disable iff (rst_int)
    (sym_valid && !sym_zero) |-> burst_on);

  // R2
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (rst_int)
    sym_valid |-> $rose(data_clk));

  // R6
  zero_symbol_data_chk: assert property (@(posedge clk) disable iff (rst_int)
    (sym_valid && sym_zero) |-> (!sym_i && !sym_q));

  // R6
  turnoff_with_last_zero_chk: assert property (@(posedge clk) disable iff (rst_int)
    $fell(burst_on) |-> (sym_valid && sym_zero));

  // R9
  start_on_tick_chk: assert property (@(posedge clk) disable iff (rst_int)
    $rose(burst_on) |-> $rose(data_clk));

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    rst_int |-> (!burst_on && !sym_valid));
endmodule

bind burst_iq_demux burst_iq_demux_chk u_chk (
  .clk       (clk),
  .rst_int   (rst_int),
  .data_clk  (data_clk),
  .burst_on  (burst_on),
  .sym_valid (sym_valid),
  .sym_i     (sym_i),
  .sym_q     (sym_q),
  .sym_zero  (sym_zero)
);

// File: tb/burst_iq_demux_test.sv
`timescale 1ns/100ps
module burst_iq_demux_test;
  localparam int DIV   = 100;
  localparam int HALF  = DIV / 2;
  localparam int FSYMS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic tx_data = 1'b0;
  logic data_clk, burst_on, sym_valid, sym_i, sym_q, sym_zero;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_iq_demux #(.DIV(DIV), .FLUSH_SYMS(FSYMS)) uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_data(tx_data),
    .data_clk(data_clk), .burst_on(burst_on), .sym_valid(sym_valid),
    .sym_i(sym_i), .sym_q(sym_q), .sym_zero(sym_zero)
  );

  // behavioural reference model
  int rel = 0;
  int mcnt = 0;
  int mstate = 0;
  int mhalf = 0;
  int mheld = 0;
  int mft = 0;
  bit m_dclk = 1, m_on = 0, m_v = 0, m_i = 0, m_q = 0, m_z = 0;
  bit [1:0] stim[$];

  task automatic model_reset();
    mcnt = 0; mstate = 0; mhalf = 0; mheld = 0; mft = 0;
    m_dclk = 1; m_on = 0; m_v = 0; m_i = 0; m_q = 0; m_z = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0;
      model_reset();
    end else if (rel < 2) begin
      rel++;
      model_reset();
    end else begin
      m_v = 0;
      if (mcnt == DIV - 1) begin
        if (mstate == 1) begin
          if (tx_en) begin
            if (mhalf == 1) begin
              m_v = 1; m_i = mheld[0]; m_q = tx_data; m_z = 0; mhalf = 0;
            end else begin
              mheld = tx_data; mhalf = 1;
            end
          end else begin
            mstate = 2; mhalf = 0; mft = 0;
          end
        end else if (tx_en) begin
          mstate = 1; mheld = tx_data; mhalf = 1; m_on = 1;
        end else if (mstate == 2) begin
          if (mft % 2 == 1) begin
            m_v = 1; m_i = 0; m_q = 0; m_z = 1;
          end
          if (mft == 2 * FSYMS - 1) begin
            mstate = 0; m_on = 0;
          end
          mft++;
        end
        mcnt = 0;
      end else begin
        mcnt++;
      end
      m_dclk = (mcnt < HALF);
    end
  end

  task automatic cmp(input string tag, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, then drive the next serial bit on the falling data-clock phase
  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R1 R8 data_clk", data_clk, m_dclk);
      cmp("R9 R6 R4 burst_on", burst_on, m_on);
      cmp("R3 R5 sym_valid", sym_valid, m_v);
      if (m_v) begin
        cmp("R2 R3 sym_i", sym_i, m_i);
        cmp("R2 R3 sym_q", sym_q, m_q);
        cmp("R6 sym_zero", sym_zero, m_z);
      end
      if (rel == 2 && mcnt == HALF) begin
        if (stim.size() > 0) begin
          bit [1:0] s;
          s = stim.pop_front();
          tx_en = s[1]; tx_data = s[0];
        end else begin
          tx_en = 1'b0; tx_data = 1'b0;
        end
      end
    end
  end

  task automatic push_burst(input int nbits, input logic [31:0] pat);
    for (int k = 0; k < nbits; k++) stim.push_back({1'b1, pat[k]});
  endtask

  task automatic push_idle(input int n);
    for (int k = 0; k < n; k++) stim.push_back(2'b00);
  endtask

  task automatic drain_stim();
    while (stim.size() > 0) @(negedge clk);
    repeat (2 * DIV) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #300000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state visible before release
    cmp("R7 reset burst_on", burst_on, 1'b0);
    cmp("R7 reset sym_valid", sym_valid, 1'b0);
    rst_n = 1'b1;
    // R8 release timing checked by per-cycle data_clk compare
    push_idle(3);
    // even burst, R3 pairing
    push_burst(10, 32'b1110001101);
    push_idle(20);
    drain_stim();
    // odd burst, R5 unpaired I dropped
    push_burst(7, 32'b0101101);
    push_idle(20);
    drain_stim();
    // R4 restart while draining
    push_burst(6, 32'b110010);
    push_idle(5);
    push_burst(4, 32'b0110);
    push_idle(20);
    drain_stim();
    // R7 reset in the middle of a burst
    push_burst(12, 32'b101010011100);
    repeat (6 * DIV) @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5;
    cmp("R7 async burst_on", burst_on, 1'b0);
    cmp("R7 async sym_valid", sym_valid, 1'b0);
    stim.delete();
    tx_en = 1'b0; tx_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 resume after reset, single short burst
    push_idle(2);
    push_burst(4, 32'b1001);
    push_idle(20);
    drain_stim();
    finish_run();
  end
endmodule